// File: doc/BRIEF.md
# Flash Sector Protection Controller

This block keeps one protection flag for each sector of a flash array and gates program and erase requests against those flags. A separate programming mode, entered through a digital flag that stands in for the elevated-voltage condition, sets a sector's flag with a single write-enable pulse. The same mode can also clear every flag at once. Flags are never touched by reset, so protection survives resets in the same way it survives power cycles on the real array.

A temporary-override flag opens every sector for program and erase while it is held. It acts only on the permission check and never alters the stored flags, so dropping it brings back exactly the protection that was in place before. In programming mode, a read cycle returns either the identifier bytes or the protection status of the addressed sector, selected by address bit 1.

Write-enable is sampled on the block clock, and edges are detected against its registered copy. The readout is a plain registered port. It has no back-pressure, because every read cycle in verify mode yields a byte on the next clock.

Top module: `secprot_top`

## Requirements
- R1: With `temp_unprot` low, `write_ok` is 0 when the sector selected by the top `SEC_W` address bits (addr[18:15] by default) has its protection flag set, and 1 when the flag is clear.
- R2: A clock edge that sees `we_n` fall while `prot_mode`=1, `ce_n`=0, `oe_n`=1 and `clr_sel`=0 latches the addressed sector. The flag is set at the clock edge that sees `we_n` rise again, and nothing is set between the two edges.
- R3: A write-enable fall has no effect when `ce_n` is high or `oe_n` is low at that edge.
- R4: In a verify read (`prot_mode`=1, `ce_n`=0, `oe_n`=0), addr[1]=1 returns `dout`=8'h01 for a protected sector and 8'h00 for an unprotected one, one clock later. Every other address bit except the sector bits is ignored.
- R5: In a verify read with addr[1]=0, `dout` is `MFR_ID` when addr[0]=0 and `DEV_ID` when addr[0]=1, one clock later, with `dout_valid`=1.
- R6: One clock after any cycle that is not a verify read, `dout` is 8'h00 and `dout_valid` is 0.
- R7: While `temp_unprot` is high, `write_ok` is 1 for every sector.
- R8: When `temp_unprot` falls, every sector that was protected before is blocked again. The stored flags are unchanged.
- R9: A write-enable pulse in programming mode with `clr_sel`=1 at the fall clears all flags at the rise.
- R10: Asserting `rst_n` low leaves every protection flag unchanged.
- R11: If `prot_mode` goes low between the fall and the rise, the pending operation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset for sequencing and readout (not the flags) |
| prot_mode | input | 1 | Programming/verify mode flag |
| temp_unprot | input | 1 | Temporary override: all sectors writable while high |
| clr_sel | input | 1 | Selects clear-all instead of set for a programming pulse |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable strobe, active low |
| addr | input | ADDR_W | Address; top bits select the sector |
| write_ok | output | 1 | Program/erase permitted for the addressed sector |
| dout | output | 8 | Verify readout byte |
| dout_valid | output | 1 | Readout byte is from a verify read |

## Verification
`write_ok` is combinational from the address, the flags and `temp_unprot`, so it is sampled one time step after the inputs are driven. A flag change is due at the clock edge that sees `we_n` rise, which is the second edge of a pulse driven over two half-cycles. Its effect is therefore checked at the falling clock edge after that. A verify read is driven at a falling edge, and `dout` is sampled at the next falling edge, after the single output register has loaded. The sector permission is also sampled between the fall and the rise of a pulse, to show that nothing changes early.

// File: rtl/secprot_pkg.sv
package secprot_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2
  } prot_op_e;
endpackage

// File: rtl/secprot_we_edge.sv
module secprot_we_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n,
  output logic we_fall,
  output logic we_rise
);
  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign we_fall = we_q & ~we_n;
  assign we_rise = ~we_q & we_n;
endmodule

// File: rtl/secprot_seq.sv
module secprot_seq
  import secprot_pkg::*;
#(
  parameter int SEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_fall,
  input  logic             we_rise,
  input  logic             prot_mode,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             clr_sel,
  input  logic [SEC_W-1:0] sector,
  output prot_op_e         commit_op,
  output logic [SEC_W-1:0] commit_sec
);
  prot_op_e         pend_op;
  logic [SEC_W-1:0] pend_sec;
  logic             start_ok;

  assign start_ok = we_fall & prot_mode & ~ce_n & oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op  <= OP_NONE;
      pend_sec <= '0;
    end else if (!prot_mode || we_rise) begin
      pend_op  <= OP_NONE;
    end else if (start_ok) begin
      pend_op  <= clr_sel ? OP_CLEAR : OP_SET;
      pend_sec <= sector;
    end
  end

  assign commit_op  = (we_rise && prot_mode) ? pend_op : OP_NONE;
  assign commit_sec = pend_sec;

  AST_NO_COMMIT_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (we_fall && !start_ok) |=> (commit_op == OP_NONE)); // R3
endmodule

// File: rtl/secprot_store.sv
module secprot_store
  import secprot_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  prot_op_e               commit_op,
  input  logic [SEC_W-1:0]       commit_sec,
  output logic [NUM_SECTORS-1:0] prot_bits
);
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (commit_op == OP_CLEAR)
        prot_bits[i] <= 1'b0;
      else if (commit_op == OP_SET && commit_sec == SEC_W'(i))
        prot_bits[i] <= 1'b1;
    end
  end

  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_op == OP_SET) |=> prot_bits[$past(commit_sec)]); // R2
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_op == OP_CLEAR) |=> (prot_bits == '0)); // R9
  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_op == OP_NONE) |=> $stable(prot_bits)); // R8
endmodule

// File: rtl/secprot_readout.sv
module secprot_readout #(
  parameter logic [7:0] MFR_ID = 8'hC2,
  parameter logic [7:0] DEV_ID = 8'hDA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_active,
  input  logic       sel_status,
  input  logic       sel_dev,
  input  logic       sec_prot,
  output logic [7:0] dout,
  output logic       dout_valid
);
  logic [7:0] rd_byte;

  always_comb begin
    if (sel_status)   rd_byte = {7'd0, sec_prot};
    else if (sel_dev) rd_byte = DEV_ID;
    else              rd_byte = MFR_ID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout       <= rd_active ? rd_byte : 8'h00;
      dout_valid <= rd_active;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |=> (dout == 8'h00 && !dout_valid)); // R6
endmodule

// File: rtl/secprot_top.sv
module secprot_top
  import secprot_pkg::*;
#(
  parameter int         NUM_SECTORS = 16,
  parameter int         ADDR_W      = 19,
  parameter logic [7:0] MFR_ID      = 8'hC2,
  parameter logic [7:0] DEV_ID      = 8'hDA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_mode,
  input  logic              temp_unprot,
  input  logic              clr_sel,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              write_ok,
  output logic [7:0]        dout,
  output logic              dout_valid
);
  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;

  logic                   we_fall, we_rise;
  prot_op_e               commit_op;
  logic [SEC_W-1:0]       commit_sec;
  logic [NUM_SECTORS-1:0] prot_bits;
  logic [SEC_W-1:0]       sector;
  logic                   sec_prot;
  logic                   rd_active;

  assign sector    = addr[ADDR_W-1 -: SEC_W];
  assign sec_prot  = prot_bits[sector];
  assign write_ok  = temp_unprot | ~sec_prot;
  assign rd_active = prot_mode & ~ce_n & ~oe_n;

  secprot_we_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_n    (we_n),
    .we_fall (we_fall),
    .we_rise (we_rise)
  );

  secprot_seq #(.SEC_W(SEC_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_fall    (we_fall),
    .we_rise    (we_rise),
    .prot_mode  (prot_mode),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .clr_sel    (clr_sel),
    .sector     (sector),
    .commit_op  (commit_op),
    .commit_sec (commit_sec)
  );

  secprot_store #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_op  (commit_op),
    .commit_sec (commit_sec),
    .prot_bits  (prot_bits)
  );

  secprot_readout #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_active  (rd_active),
    .sel_status (addr[1]),
    .sel_dev    (addr[0]),
    .sec_prot   (sec_prot),
    .dout       (dout),
    .dout_valid (dout_valid)
  );
endmodule

// File: tb/secprot_top_test.sv
module secprot_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam logic [7:0] MFR = 8'hC2;
  localparam logic [7:0] DEV = 8'hDA;
  // {protect, sector}
  localparam logic [4:0] VEC [0:7] = '{5'h10, 5'h03, 5'h1F, 5'h07,
                                       5'h19, 5'h0A, 5'h15, 5'h0C};

  logic clk = 1'b0;
  logic rst_n, prot_mode, temp_unprot, clr_sel, ce_n, oe_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic write_ok, dout_valid;
  logic [7:0] dout;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secprot_top #(.ADDR_W(ADDR_W), .MFR_ID(MFR), .DEV_ID(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .temp_unprot(temp_unprot),
    .clr_sel(clr_sel), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .write_ok(write_ok), .dout(dout), .dout_valid(dout_valid));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input logic [3:0] sec, input logic a1, input logic a0);
    return {sec, 13'h15A6 ^ {5'd0, sec, 4'd0}, a1, a0};
  endfunction

  // one write-enable pulse; flag effect visible at return
  task automatic pulse(input logic [3:0] sec, input logic clr, input logic ce, input logic oe);
    @(negedge clk);
    prot_mode = 1; ce_n = ce; oe_n = oe; clr_sel = clr; addr = mk(sec, 0, 0); we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 0; oe_n = 1; clr_sel = 0; prot_mode = 0;
  endtask

  task automatic vread(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    prot_mode = 1; ce_n = 0; oe_n = 0; addr = a;
    @(negedge clk);
    oe_n = 1; prot_mode = 0;
  endtask

  task automatic wok(input logic [3:0] sec, output logic r);
    addr = mk(sec, 0, 1); #1; r = write_ok;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic r;
    logic [7:0] d;
    logic v;
    rst_n = 0; prot_mode = 0; temp_unprot = 0; clr_sel = 0;
    ce_n = 1; oe_n = 1; we_n = 1; addr = '0;
    repeat (3) @(negedge clk);
    chk("R6 reset dout", dout, 8'h00);
    chk("R6 reset valid", dout_valid, 0);
    rst_n = 1;

    pulse(4'd0, 1, 0, 1);
    for (int s = 0; s < 16; s++) begin
      wok(4'(s), r);
      if (s == 0 || s == 15) chk("R9 clear all", r, 1);
    end

    // table walk: program flagged sectors, then check all
    for (int i = 0; i < 8; i++) if (VEC[i][4]) pulse(VEC[i][3:0], 0, 0, 1);
    for (int i = 0; i < 8; i++) begin
      wok(VEC[i][3:0], r);
      chk("R1 write_ok", r, !VEC[i][4]);
      vread(mk(VEC[i][3:0], 1, i[0]));
      chk("R4 status", dout, {7'd0, VEC[i][4]});
    end

    vread(mk(4'd3, 0, 0)); chk("R5 mfr", dout, MFR);
    vread(mk(4'd9, 0, 1)); chk("R5 dev", dout, DEV);
    chk("R5 valid", dout_valid, 1);
    @(negedge clk); chk("R6 idle dout", dout, 8'h00); chk("R6 idle valid", dout_valid, 0);

    // R2: nothing set between fall and rise
    @(negedge clk);
    prot_mode = 1; ce_n = 0; oe_n = 1; addr = mk(4'd3, 0, 0); we_n = 0;
    @(negedge clk); #1; chk("R2 not early", write_ok, 1);
    we_n = 1;
    @(negedge clk); prot_mode = 0; wok(4'd3, r); chk("R2 set after rise", r, 0);

    pulse(4'd7, 0, 1, 1); wok(4'd7, r); chk("R3 ce high ignored", r, 1);
    pulse(4'd7, 0, 0, 0); wok(4'd7, r); chk("R3 oe low ignored", r, 1);

    // R11 abandon
    @(negedge clk);
    prot_mode = 1; ce_n = 0; oe_n = 1; addr = mk(4'd10, 0, 0); we_n = 0;
    @(negedge clk); prot_mode = 0;
    @(negedge clk); we_n = 1; prot_mode = 1;
    @(negedge clk); prot_mode = 0;
    wok(4'd10, r); chk("R11 abandoned", r, 1);

    @(negedge clk); temp_unprot = 1;
    wok(4'd0, r); chk("R7 temp open", r, 1);
    wok(4'd15, r); chk("R7 temp open", r, 1);
    @(negedge clk); temp_unprot = 0;
    wok(4'd15, r); chk("R8 restored", r, 0);
    vread(mk(4'd9, 1, 0)); chk("R8 bit kept", dout, 8'h01);

    @(negedge clk); rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    wok(4'd5, r); chk("R10 reset keeps", r, 0);
    wok(4'd12, r); chk("R10 reset keeps", r, 1);

    pulse(4'd0, 1, 0, 1);
    wok(4'd9, r); chk("R9 cleared", r, 1);
    vread(mk(4'd5, 1, 1)); d = dout; v = dout_valid;
    chk("R9 status cleared", d, 8'h00); chk("R4 valid", v, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule